// File: doc/BRIEF.md
# HI/LO Multiply-Divide Unit

This block is the multiply and divide unit of a 32-bit RISC integer core. It owns a pair of 32-bit registers, HI and LO, which together hold one 64-bit value. The core issues an operation code with two operands, `rs` and `rt`, by raising `start_i`. Products are split across the pair. Divides put the remainder in HI and the quotient in LO. Multiply-add and multiply-subtract accumulate into the whole 64-bit pair. Plain moves read or load either half.

Multiplies and divides are computed one bit per cycle. The multiplier is a shift-add array and the divider is restoring shift-subtract. Both work on operand magnitudes and apply a sign correction at the end. The core sees a fixed latency. `busy_o` is high while an operation is in flight, and a request presented then is not taken. A requester that wants HI or LO holds `start_i` until the unit is free. A separate 32-bit multiply returns the low product word on `result_o` and does not touch HI and LO.

Top module: `mdu_hilo`

## Requirements
- R1: Op 0 (signed) and op 1 (unsigned) multiply rs by rt. They write product bits [63:32] to HI and bits [31:0] to LO.
- R2: Op 2 (signed) and op 3 (unsigned) divide rs by rt. They write the quotient to LO and the remainder to HI. The signed quotient truncates toward zero and the remainder takes the sign of rs. The quotient of -2^31 by -1 wraps to 0x80000000 with remainder 0.
- R3: A divide with rt equal to zero completes with the normal latency. It leaves HI equal to rs and LO equal to 0xFFFFFFFF, for both signed and unsigned ops.
- R4: Op 4 (signed) and op 5 (unsigned) add the 64-bit product rs*rt to {HI,LO}, modulo 2^64.
- R5: Op 6 (signed) and op 7 (unsigned) subtract the 64-bit product rs*rt from {HI,LO}, modulo 2^64.
- R6: Op 8 puts HI on `result_o` and op 9 puts LO on `result_o`. Each is valid in the cycle after the accepting edge, with a one-cycle `done_o` and no `busy_o`.
- R7: Op 10 loads HI from rs and op 11 loads LO from rs. Each completes in one cycle.
- R8: Op 12 puts the low 32 bits of the signed product rs*rt on `result_o` and leaves HI and LO unchanged.
- R9: An op from 0 to 7 or an op 12 holds `busy_o` high for 33 cycles after the accepting edge. `done_o` is then high for exactly one cycle, with `busy_o` low.
- R10: While `busy_o` is high, `start_i` is ignored and HI and LO do not change. A held move-from request is served after the unit becomes free and returns the new value.
- R11: After reset HI, LO and `result_o` are zero, and `busy_o` and `done_o` are low.
- R12: Op codes 13 to 15 give a one-cycle `done_o` and change neither HI, LO nor `result_o`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request; taken on a clock edge when not busy |
| op_i | input | 4 | Operation code |
| rs_i | input | 32 | First operand |
| rt_i | input | 32 | Second operand |
| busy_o | output | 1 | Iterative operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| result_o | output | 32 | Move-from value or 32-bit product |
| hi_o | output | 32 | HI register |
| lo_o | output | 32 | LO register |

## Verification
The assertions check on every cycle that `done_o` never coincides with `busy_o`. They also check that the fall of `busy_o` is always followed by a completion and that HI and LO hold still during an iterative operation and across a 32-bit multiply. Inside the divider, an assertion checks that the partial remainder stays below a nonzero divisor. The arithmetic results, the signed truncation cases, the divide-by-zero values, the exact 33-cycle busy window and the deferred move-from request can only be shown by the bench scenarios, which compare against a 64-bit reference model.

// File: rtl/mdu_pkg.sv
package mdu_pkg;
  localparam int unsigned OP_W = 4;

  typedef enum logic [OP_W-1:0] {
    OP_MULT  = 4'd0,
    OP_MULTU = 4'd1,
    OP_DIV   = 4'd2,
    OP_DIVU  = 4'd3,
    OP_MADD  = 4'd4,
    OP_MADDU = 4'd5,
    OP_MSUB  = 4'd6,
    OP_MSUBU = 4'd7,
    OP_MFHI  = 4'd8,
    OP_MFLO  = 4'd9,
    OP_MTHI  = 4'd10,
    OP_MTLO  = 4'd11,
    OP_MUL32 = 4'd12
  } mdu_op_e;
endpackage

// File: rtl/mdu_mul_seq.sv
// Shift-add multiplier on magnitudes, one multiplier bit per step.
module mdu_mul_seq #(
  parameter int unsigned W = 32
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           load_i,
  input  logic           step_i,
  input  logic [W-1:0]   a_i,
  input  logic [W-1:0]   b_i,
  output logic [2*W-1:0] prod_o
);
  logic [2*W-1:0] p_q;
  logic [W-1:0]   a_q;
  logic [W:0]     sum;

  assign sum = {1'b0, p_q[2*W-1:W]} + (p_q[0] ? {1'b0, a_q} : '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      p_q <= '0;
      a_q <= '0;
    end else if (load_i) begin
      p_q <= {{W{1'b0}}, b_i};
      a_q <= a_i;
    end else if (step_i) begin
      p_q <= {sum, p_q[W-1:1]};
    end
  end

  assign prod_o = p_q;

  // R1: a zero multiplicand never accumulates anything into the upper half
  a_r1_zero_mcand: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !load_i && a_q == '0 && p_q[2*W-1:W] == '0) |=> p_q[2*W-1:W-1] == '0);
endmodule

// File: rtl/mdu_div_seq.sv
// Restoring divider on magnitudes, one quotient bit per step.
module mdu_div_seq #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic         step_i,
  input  logic [W-1:0] n_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] quo_o,
  output logic [W-1:0] rem_o
);
  logic [W-1:0] rem_q, quo_q, d_q;
  logic [W:0]   shifted, trial;
  logic         ge;

  assign shifted = {rem_q, quo_q[W-1]};
  assign trial   = shifted - {1'b0, d_q};
  assign ge      = ~trial[W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rem_q <= '0;
      quo_q <= '0;
      d_q   <= '0;
    end else if (load_i) begin
      rem_q <= '0;
      quo_q <= n_i;
      d_q   <= d_i;
    end else if (step_i) begin
      rem_q <= ge ? trial[W-1:0] : shifted[W-1:0];
      quo_q <= {quo_q[W-2:0], ge};
    end
  end

  assign quo_o = quo_q;
  assign rem_o = rem_q;

  // R2: partial remainder stays below a nonzero divisor
  a_r2_rem_below_divisor: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (d_q != '0) |-> (rem_q < d_q));
endmodule

// File: rtl/mdu_hilo.sv
module mdu_hilo
  import mdu_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  logic [OP_W-1:0] op_i,
  input  logic [W-1:0]    rs_i,
  input  logic [W-1:0]    rt_i,
  output logic            busy_o,
  output logic            done_o,
  output logic [W-1:0]    result_o,
  output logic [W-1:0]    hi_o,
  output logic [W-1:0]    lo_o
);
  localparam int unsigned CW = $clog2(W + 1);
  localparam logic [CW-1:0] LAST = CW'(W);

  mdu_op_e        op_in, op_q;
  logic           is_iter, is_signed, a_neg, b_neg, accept;
  logic [W-1:0]   mag_a, mag_b;
  logic           busy_q, done_q, neg_p_q, neg_r_q, dz_q;
  logic [CW-1:0]  cnt_q;
  logic [W-1:0]   hi_q, lo_q, res_q, rs_q;
  logic [2*W-1:0] prod, prod_s, hilo;
  logic [W-1:0]   quo, rem, quo_s, rem_s;
  logic           step;

  assign op_in     = mdu_op_e'(op_i);
  assign accept    = start_i && !busy_q;
  assign is_iter   = op_in inside {OP_MULT, OP_MULTU, OP_DIV, OP_DIVU, OP_MADD,
                                   OP_MADDU, OP_MSUB, OP_MSUBU, OP_MUL32};
  assign is_signed = op_in inside {OP_MULT, OP_DIV, OP_MADD, OP_MSUB, OP_MUL32};
  assign a_neg     = is_signed && rs_i[W-1];
  assign b_neg     = is_signed && rt_i[W-1];
  assign mag_a     = a_neg ? (~rs_i + 1'b1) : rs_i;
  assign mag_b     = b_neg ? (~rt_i + 1'b1) : rt_i;
  assign step      = busy_q && (cnt_q != LAST);

  mdu_mul_seq #(.W(W)) i_mul (
    .clk_i, .rst_ni,
    .load_i (accept && is_iter),
    .step_i (step),
    .a_i    (mag_a),
    .b_i    (mag_b),
    .prod_o (prod)
  );

  mdu_div_seq #(.W(W)) i_div (
    .clk_i, .rst_ni,
    .load_i (accept && is_iter),
    .step_i (step),
    .n_i    (mag_a),
    .d_i    (mag_b),
    .quo_o  (quo),
    .rem_o  (rem)
  );

  assign prod_s = neg_p_q ? (~prod + 1'b1) : prod;
  assign quo_s  = neg_p_q ? (~quo + 1'b1) : quo;
  assign rem_s  = neg_r_q ? (~rem + 1'b1) : rem;
  assign hilo   = {hi_q, lo_q};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      op_q    <= OP_MULT;
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      neg_p_q <= 1'b0;
      neg_r_q <= 1'b0;
      dz_q    <= 1'b0;
      cnt_q   <= '0;
      hi_q    <= '0;
      lo_q    <= '0;
      res_q   <= '0;
      rs_q    <= '0;
    end else begin
      done_q <= 1'b0;
      if (accept) begin
        if (is_iter) begin
          busy_q  <= 1'b1;
          cnt_q   <= '0;
          op_q    <= op_in;
          neg_p_q <= a_neg ^ b_neg;
          neg_r_q <= a_neg;
          dz_q    <= (rt_i == '0);
          rs_q    <= rs_i;
        end else begin
          done_q <= 1'b1;
          case (op_in)
            OP_MFHI: res_q <= hi_q;
            OP_MFLO: res_q <= lo_q;
            OP_MTHI: hi_q  <= rs_i;
            OP_MTLO: lo_q  <= rs_i;
            default: ;
          endcase
        end
      end else if (step) begin
        cnt_q <= cnt_q + 1'b1;
      end else if (busy_q) begin
        busy_q <= 1'b0;
        done_q <= 1'b1;
        case (op_q)
          OP_MULT, OP_MULTU: {hi_q, lo_q} <= prod_s;
          OP_MADD, OP_MADDU: {hi_q, lo_q} <= hilo + prod_s;
          OP_MSUB, OP_MSUBU: {hi_q, lo_q} <= hilo - prod_s;
          OP_DIV, OP_DIVU: begin
            hi_q <= dz_q ? rs_q : rem_s;
            lo_q <= dz_q ? '1 : quo_s;
          end
          OP_MUL32: res_q <= prod_s[W-1:0];
          default: ;
        endcase
      end
    end
  end

  assign busy_o   = busy_q;
  assign done_o   = done_q;
  assign result_o = res_q;
  assign hi_o     = hi_q;
  assign lo_o     = lo_q;

  a_r9_done_not_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);
  a_r9_fall_gives_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> done_o);
  a_r10_busy_until_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> (busy_o || done_o));
  a_r10_hilo_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o)) |-> ($stable(hi_o) && $stable(lo_o)));
  a_r8_mul32_keeps_hilo: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && op_q == OP_MUL32) |=> ($stable(hi_o) && $stable(lo_o)));
endmodule

// File: tb/test_mdu_hilo.sv
module test_mdu_hilo;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [3:0]  op = '0;
  logic [31:0] rs = '0, rt = '0;
  logic        busy, done;
  logic [31:0] result, hi, lo;
  int checks = 0;
  int errors = 0;
  logic [31:0] hm = '0, lm = '0, resm = '0;

  always #5 clk = ~clk;

  mdu_hilo i_mdu_hilo (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .op_i(op),
    .rs_i(rs), .rt_i(rt), .busy_o(busy), .done_o(done),
    .result_o(result), .hi_o(hi), .lo_o(lo)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] mprod(input logic sg, input logic [31:0] a, input logic [31:0] b);
    logic [63:0] x, y;
    x = sg ? {{32{a[31]}}, a} : {32'd0, a};
    y = sg ? {{32{b[31]}}, b} : {32'd0, b};
    return x * y;
  endfunction

  function automatic logic [63:0] mdiv(input logic sg, input logic [31:0] a, input logic [31:0] b);
    longint x, y, q, r;
    if (b == 0) return {a, 32'hFFFF_FFFF};
    x = sg ? longint'($signed(a)) : longint'({32'd0, a});
    y = sg ? longint'($signed(b)) : longint'({32'd0, b});
    q = x / y;
    r = x % y;
    return {r[31:0], q[31:0]};
  endfunction

  function automatic string tag(input logic [3:0] o);
    case (o)
      0, 1: return "R1";
      2, 3: return "R2";
      4, 5: return "R4";
      6, 7: return "R5";
      8, 9: return "R6";
      10, 11: return "R7";
      12: return "R8";
      default: return "R12";
    endcase
  endfunction

  // reference model update
  task automatic model(input logic [3:0] o, input logic [31:0] a, input logic [31:0] b);
    logic [63:0] p;
    p = mprod(!o[0], a, b);
    case (o)
      0, 1: {hm, lm} = p;
      2, 3: {hm, lm} = mdiv(!o[0], a, b);
      4, 5: {hm, lm} = {hm, lm} + p;
      6, 7: {hm, lm} = {hm, lm} - p;
      8: resm = hm;
      9: resm = lm;
      10: hm = a;
      11: lm = a;
      12: resm = mprod(1'b1, a, b) >> 0;
      default: ;
    endcase
    if (o == 12) resm = p[31:0];
  endtask

  task automatic run_op(input logic [3:0] o, input logic [31:0] a, input logic [31:0] b);
    int lat, bcnt, exp_lat;
    string t;
    t = tag(o);
    if (b == 0 && (o == 2 || o == 3)) t = "R3";
    @(negedge clk);
    start = 1'b1; op = o; rs = a; rt = b;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    lat = 1; bcnt = 0;
    while (!done && lat < 200) begin
      if (busy) bcnt++;
      @(negedge clk);
      lat++;
    end
    model(o, a, b);
    exp_lat = (o <= 7 || o == 12) ? 34 : 1;
    check({"R9 latency ", t}, lat, exp_lat);
    check({"R9 busy cycles ", t}, bcnt, exp_lat - 1);
    check({t, " hi"}, hi, hm);
    check({t, " lo"}, lo, lm);
    check({t, " result"}, result, resm);
    @(negedge clk);
    check("R9 done one cycle", done, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog R9 actual hung expected completion");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [3:0] o;
    logic [31:0] a, b;
    int lat;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    // R11 reset state
    check("R11 hi", hi, 0);
    check("R11 lo", lo, 0);
    check("R11 busy", busy, 0);
    check("R11 done", done, 0);
    check("R11 result", result, 0);
    rst_n = 1'b1;
    @(negedge clk);

    run_op(0, 32'h8000_0000, 32'h8000_0000);
    run_op(1, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    run_op(0, 32'hFFFF_FFFD, 32'd7);
    run_op(2, 32'hFFFF_FFF9, 32'd2);       // -7/2
    run_op(2, 32'd7, 32'hFFFF_FFFE);       // 7/-2
    run_op(2, 32'h8000_0000, 32'hFFFF_FFFF);
    run_op(3, 32'hFFFF_FFFF, 32'd10);
    run_op(3, 32'h1234_5678, 32'd0);       // R3
    run_op(2, 32'hFFFF_FF00, 32'd0);       // R3 negative dividend
    run_op(10, 32'h0000_0001, 0);
    run_op(11, 32'hFFFF_FFFF, 0);
    run_op(4, 32'hFFFF_FFFF, 32'd2);
    run_op(5, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    run_op(6, 32'h8000_0000, 32'd3);
    run_op(7, 32'd5, 32'd9);
    run_op(8, 0, 0);
    run_op(9, 0, 0);
    run_op(12, 32'hFFFF_FFFB, 32'h1000_0003);
    run_op(13, 32'h55, 32'h66);
    run_op(15, 32'h55, 32'h66);

    // R10: requests while busy are dropped; HI/LO hold
    @(negedge clk);
    start = 1'b1; op = 4'd2; rs = 32'd100; rt = 32'd7;
    @(posedge clk);
    @(negedge clk);
    op = 4'd10; rs = 32'hDEAD_BEEF;
    repeat (5) begin
      check("R10 hi held while busy", hi, hm);
      @(negedge clk);
    end
    start = 1'b0;
    lat = 0;
    while (!done && lat < 200) begin @(negedge clk); lat++; end
    model(4'd2, 32'd100, 32'd7);
    check("R10 hi after ignored move", hi, hm);
    check("R10 lo after ignored move", lo, lm);
    @(negedge clk);
    check("R10 no extra done", done, 0);

    // R10: held move-from waits and returns the fresh HI
    @(negedge clk);
    start = 1'b1; op = 4'd3; rs = 32'd1000; rt = 32'd33;
    @(posedge clk);
    @(negedge clk);
    op = 4'd8;
    lat = 0;
    while (!done && lat < 200) begin @(negedge clk); lat++; end
    model(4'd3, 32'd1000, 32'd33);
    @(negedge clk);
    start = 1'b0;
    check("R10 held move-from done", done, 1);
    check("R10 held move-from value", result, hm);
    resm = hm;

    // constrained random mix
    for (int i = 0; i < 150; i++) begin
      o = 4'($urandom_range(0, 15));
      a = $urandom;
      b = $urandom;
      case ($urandom_range(0, 7))
        0: b = 32'd0;
        1: a = 32'h8000_0000;
        2: b = 32'($urandom_range(1, 5));
        default: ;
      endcase
      run_op(o, a, b);
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule